// File: doc/BRIEF.md
# Paired Fallback Slot Arbiter

This block arbitrates a shared memory port among 16 requesters by scanning a programmable slot table. One slot counter steps once per clock. In each slot a table entry names the requester that owns that slot. Each requester raises a "needs access next" flag one clock ahead of its operation. The arbiter answers with a granted requester ID and a valid bit, two clocks after it sampled the flags.

The 32 entries of storage can be used in two ways. In single-table mode, each slot of a scan of up to 32 slots reads one entry. In paired mode, the storage splits into two 16-entry halves that the same counter reads in lockstep. The low half names a primary owner and the high half names a secondary owner. The primary owner wins the slot whenever it requests. If it does not request, the slot falls through to the secondary owner in the same cycle.

A force bit ignores both tables and gives plain 1:16 round robin. Table writes land in a pending copy that becomes active when a scan round ends, so a round never mixes old and new entries.

Top module: `pair_slot_arb`

## Requirements
- R1: While rst_ni is low and until the first two clock edges after its release, grant_valid_o is 0 and grant_id_o is 0. Every table entry e (0..31) resets to e mod 16, and the slot counter resets to 0.
- R2: With pair_mode_i=0 and force_rr_i=0, slot s (0..31) takes its owner from entry s, and that owner is also its only candidate.
- R3: The slot counter steps from 0 up to a last slot and then returns to 0. The last slot is scan_last_i in single-table mode and min(scan_last_i,15) in paired mode. If the counter already lies at or above the last slot, it returns to 0 on the next edge.
- R4: In paired mode, slot s (0..15) has its primary owner in entry s and its secondary owner in entry 16+s. The primary owner is granted whenever its need bit is set.
- R5: In paired mode, when the primary owner's need bit is clear and the secondary owner's need bit is set, the secondary owner is granted. Filling entries 16..31 with 0 gives requester 0 every slot left unused by its owner.
- R6: A slot whose primary and secondary entries hold the same ID is never granted to any other requester.
- R7: When no candidate of a slot requests, grant_valid_o is 0 and grant_id_o shows the primary owner.
- R8: With force_rr_i=1, the tables and scan_last_i are ignored. The slot counter runs 0..15, and slot s is owned solely by requester s.
- R9: The need_i value sampled at the edge that ends cycle t is paired with the slot of cycle t. The result appears on the outputs in cycle t+2.
- R10: When wr_en_i=1, wr_id_i is written to pending entry wr_idx_i. On the edge where the counter leaves its last slot, the whole pending copy, including a write on that same edge, becomes the active table. Slots read only the active table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_mode_i | input | 1 | 1: paired primary/secondary tables, 0: single 32-entry table |
| force_rr_i | input | 1 | 1: fixed 1:16 round robin, tables ignored |
| scan_last_i | input | 5 | Last slot index of the scan (length minus one) |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 5 | Table entry written |
| wr_id_i | input | 4 | Requester ID written |
| need_i | input | 16 | Per-requester need-access-next flags |
| grant_valid_o | output | 1 | A requester is granted the slot |
| grant_id_o | output | 4 | Granted requester, or nominal primary owner when not valid |

## Verification
The assertions assume that need_i is the flag vector sampled two clocks before the grant it justifies. They also assume that a mode or force change may leave the counter above the new last slot for at most one cycle. The stimulus changes inputs only on the falling clock edge. Between the random phases it holds modes for many cycles, and it keeps scan_last_i within the 5-bit range, so every counter window the properties rely on is entered from a defined reset state.

// File: rtl/pair_slot_arb_pkg.sv
package pair_slot_arb_pkg;
  localparam int N_REQ  = 16;
  localparam int N_ENT  = 32;
  localparam int ID_W   = $clog2(N_REQ);
  localparam int SLOT_W = $clog2(N_ENT);
  localparam int HALF   = N_ENT / 2;
endpackage

// File: rtl/pair_slot_arb_ctr.sv
module pair_slot_arb_ctr #(
  parameter int SLOT_W = 5,
  parameter int HALF   = 16,
  parameter int N_REQ  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_mode_i,
  input  logic              force_rr_i,
  input  logic [SLOT_W-1:0] scan_last_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o
);
  localparam logic [SLOT_W-1:0] HALF_LAST = SLOT_W'(HALF - 1);
  localparam logic [SLOT_W-1:0] RR_LAST   = SLOT_W'(N_REQ - 1);

  logic [SLOT_W-1:0] slot_q, last;

  always_comb begin
    if (force_rr_i)       last = RR_LAST;
    else if (pair_mode_i) last = (scan_last_i > HALF_LAST) ? HALF_LAST : scan_last_i;
    else                  last = scan_last_i;
  end

  assign wrap_o = (slot_q >= last);
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (wrap_o) slot_q <= '0;
    else             slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/pair_slot_arb_tbl.sv
module pair_slot_arb_tbl #(
  parameter int N_ENT = 32,
  parameter int N_REQ = 16,
  parameter int ID_W  = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [ID_W-1:0]  rd_a_o,
  output logic [ID_W-1:0]  rd_b_o
);
  logic [N_ENT*ID_W-1:0] act_flat;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [ID_W-1:0] DEF = ID_W'(e % N_REQ);
    logic [ID_W-1:0] pend_q, act_q;
    logic            hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= DEF;
        act_q  <= DEF;
      end else begin
        if (hit)      pend_q <= wr_id_i;
        if (commit_i) act_q  <= hit ? wr_id_i : pend_q;
      end
    end
    assign act_flat[e*ID_W +: ID_W] = act_q;
  end

  assign rd_a_o = act_flat[rd_a_idx_i*ID_W +: ID_W];
  assign rd_b_o = act_flat[rd_b_idx_i*ID_W +: ID_W];
endmodule

// File: rtl/pair_slot_arb_pick.sv
module pair_slot_arb_pick #(
  parameter int N_REQ = 16,
  parameter int ID_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  prim_i,
  input  logic [ID_W-1:0]  sec_i,
  input  logic [N_REQ-1:0] need_i,
  output logic             grant_valid_o,
  output logic [ID_W-1:0]  grant_id_o
);
  // stage 1: owners of the slot plus the early need flags
  logic [ID_W-1:0]  prim_q, sec_q;
  logic [N_REQ-1:0] need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q <= '0;
      sec_q  <= '0;
      need_q <= '0;
    end else begin
      prim_q <= prim_i;
      sec_q  <= sec_i;
      need_q <= need_i;
    end
  end

  // stage 2: primary first, secondary falls back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_id_o    <= '0;
    end else if (need_q[prim_q]) begin
      grant_valid_o <= 1'b1;
      grant_id_o    <= prim_q;
    end else if (need_q[sec_q]) begin
      grant_valid_o <= 1'b1;
      grant_id_o    <= sec_q;
    end else begin
      grant_valid_o <= 1'b0;
      grant_id_o    <= prim_q;
    end
  end
endmodule

// File: rtl/pair_slot_arb.sv
module pair_slot_arb
  import pair_slot_arb_pkg::*;
#(
  parameter int P_N_REQ = N_REQ,
  parameter int P_N_ENT = N_ENT,
  localparam int P_ID_W   = $clog2(P_N_REQ),
  localparam int P_SLOT_W = $clog2(P_N_ENT),
  localparam int P_HALF   = P_N_ENT / 2,
  localparam int P_HALF_W = P_SLOT_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pair_mode_i,
  input  logic                force_rr_i,
  input  logic [P_SLOT_W-1:0] scan_last_i,
  input  logic                wr_en_i,
  input  logic [P_SLOT_W-1:0] wr_idx_i,
  input  logic [P_ID_W-1:0]   wr_id_i,
  input  logic [P_N_REQ-1:0]  need_i,
  output logic                grant_valid_o,
  output logic [P_ID_W-1:0]   grant_id_o
);
  logic [P_SLOT_W-1:0] slot_q, rd_a_idx, rd_b_idx;
  logic                wrap;
  logic [P_ID_W-1:0]   rd_a, rd_b, prim, sec;

  pair_slot_arb_ctr #(.SLOT_W(P_SLOT_W), .HALF(P_HALF), .N_REQ(P_N_REQ)) u_ctr (
    .clk_i, .rst_ni, .pair_mode_i, .force_rr_i, .scan_last_i,
    .slot_o(slot_q), .wrap_o(wrap)
  );

  assign rd_a_idx = pair_mode_i ? {1'b0, slot_q[P_HALF_W-1:0]} : slot_q;
  assign rd_b_idx = {1'b1, slot_q[P_HALF_W-1:0]};

  pair_slot_arb_tbl #(.N_ENT(P_N_ENT), .N_REQ(P_N_REQ), .ID_W(P_ID_W), .IDX_W(P_SLOT_W)) u_tbl (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_id_i,
    .commit_i(wrap), .rd_a_idx_i(rd_a_idx), .rd_b_idx_i(rd_b_idx),
    .rd_a_o(rd_a), .rd_b_o(rd_b)
  );

  always_comb begin
    if (force_rr_i) begin
      prim = slot_q[P_ID_W-1:0];
      sec  = prim;
    end else if (pair_mode_i) begin
      prim = rd_a;
      sec  = rd_b;
    end else begin
      prim = rd_a;
      sec  = rd_a;
    end
  end

  pair_slot_arb_pick #(.N_REQ(P_N_REQ), .ID_W(P_ID_W)) u_pick (
    .clk_i, .rst_ni, .prim_i(prim), .sec_i(sec), .need_i,
    .grant_valid_o, .grant_id_o
  );
endmodule

// File: rtl/pair_slot_arb_chk.sv
module pair_slot_arb_chk #(
  parameter int N_REQ  = 16,
  parameter int ID_W   = 4,
  parameter int SLOT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pair_mode_i,
  input logic              force_rr_i,
  input logic [N_REQ-1:0]  need_i,
  input logic              grant_valid_o,
  input logic [ID_W-1:0]   grant_id_o,
  input logic [SLOT_W-1:0] slot_q
);
  AST_GRANT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ((($past(need_i, 2)) >> grant_id_o) & 1) != 0); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(need_i, 2) == '0) |-> !grant_valid_o); // R7
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != '0) |-> (slot_q == $past(slot_q) + 1'b1)); // R3
  AST_PAIR_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pair_mode_i || force_rr_i) |-> (slot_q < SLOT_W'(16))); // R3
  AST_FORCE_RR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(force_rr_i, 2) |-> (grant_id_o == $past(slot_q[ID_W-1:0], 2))); // R8
endmodule

bind pair_slot_arb pair_slot_arb_chk #(.N_REQ(P_N_REQ), .ID_W(P_ID_W), .SLOT_W(P_SLOT_W)) u_chk (
  .clk_i, .rst_ni, .pair_mode_i, .force_rr_i, .need_i,
  .grant_valid_o, .grant_id_o, .slot_q(slot_q)
);

// File: tb/pair_slot_arb_tb_top.sv
`timescale 1ns/1ps
module pair_slot_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_mode = 1'b0, force_rr = 1'b0, wr_en = 1'b0;
  logic [4:0]  scan_last = 5'd31, wr_idx = '0;
  logic [3:0]  wr_id = '0;
  logic [15:0] need = '0;
  logic        g_valid;
  logic [3:0]  g_id;

  int n_chk = 0, n_bad = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  pair_slot_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pair_mode_i(pair_mode), .force_rr_i(force_rr),
    .scan_last_i(scan_last), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_id_i(wr_id),
    .need_i(need), .grant_valid_o(g_valid), .grant_id_o(g_id)
  );

  // reference model built from the requirements
  logic [3:0]  m_pend[32], m_act[32];
  logic [4:0]  m_slot;
  logic [3:0]  m_p1, m_s1, m_id;
  logic [15:0] m_need1;
  logic        m_v;

  function automatic logic [4:0] eff_last(logic f, logic p, logic [4:0] l);
    if (f) return 5'd15;
    if (p) return (l > 5'd15) ? 5'd15 : l;
    return l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 32; e++) begin m_pend[e] = 4'(e % 16); m_act[e] = 4'(e % 16); end
      m_slot = '0; m_p1 = '0; m_s1 = '0; m_need1 = '0; m_v = 1'b0; m_id = '0;
    end else begin
      if (m_need1[m_p1])      begin m_v = 1'b1; m_id = m_p1; end
      else if (m_need1[m_s1]) begin m_v = 1'b1; m_id = m_s1; end
      else                    begin m_v = 1'b0; m_id = m_p1; end
      if (force_rr)       begin m_p1 = m_slot[3:0]; m_s1 = m_p1; end
      else if (pair_mode) begin m_p1 = m_act[{1'b0, m_slot[3:0]}]; m_s1 = m_act[{1'b1, m_slot[3:0]}]; end
      else                begin m_p1 = m_act[m_slot]; m_s1 = m_p1; end
      m_need1 = need;
      if (wr_en) m_pend[wr_idx] = wr_id;
      if (m_slot >= eff_last(force_rr, pair_mode, scan_last)) begin
        for (int e = 0; e < 32; e++) m_act[e] = m_pend[e];
        m_slot = '0;
      end else m_slot = m_slot + 1'b1;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(tag, {7'd0, g_valid}, {7'd0, m_v});
      check(tag, {4'd0, g_id}, {4'd0, m_id});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] idx, logic [3:0] id);
    wr_en = 1'b1; wr_idx = idx; wr_id = id;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rand_run(int n, bit do_wr);
    for (int i = 0; i < n; i++) begin
      need = 16'($urandom) & 16'($urandom);
      if (do_wr && ($urandom % 4 == 0)) begin
        wr_en = 1'b1; wr_idx = 5'($urandom); wr_id = 4'($urandom);
      end else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  // counts valid grants to one requester over n cycles
  task automatic count_grants(int n, logic [3:0] who, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (g_valid && g_id == who) cnt++;
    end
  endtask

  initial begin
    int cnt;
    void'($urandom(32'h5eed));
    cyc(3);
    // R1 reset state
    check("R1", {7'd0, g_valid}, 8'd0);
    check("R1", {4'd0, g_id}, 8'd0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    cyc(2);
    // R2 single table, default entries, everyone requesting
    tag = "R2"; need = 16'hffff; cyc(40);
    tag = "R2"; rand_run(80, 1'b0);
    // R3 varied scan lengths, and clamp in paired mode
    tag = "R3";
    for (int k = 0; k < 6; k++) begin scan_last = 5'($urandom); rand_run(40, 1'b0); end
    pair_mode = 1'b1; scan_last = 5'd31; rand_run(50, 1'b0);
    scan_last = 5'd6; rand_run(30, 1'b0);
    // R6 default paired table: secondary equals primary
    tag = "R6"; scan_last = 5'd15; rand_run(60, 1'b0);
    // R4 pairing slot 1 with requester 9
    tag = "R4"; wr(5'd17, 4'd9); need = 16'h0202; cyc(40);
    count_grants(32, 4'd9, cnt);
    check("R4", 8'(cnt), 8'd2);
    tag = "R5"; need = 16'h0200; cyc(4);
    count_grants(32, 4'd9, cnt);
    check("R5", 8'(cnt), 8'd4);
    // R5 secondary table all 0: requester 0 takes spare slots
    for (int e = 16; e < 32; e++) wr(5'(e), 4'd0);
    need = 16'h0021; cyc(40);
    count_grants(32, 4'd0, cnt);
    check("R5", 8'(cnt), 8'd30);
    // R5 alternating 0,1 secondary
    for (int e = 16; e < 32; e++) wr(5'(e), 4'(e % 2));
    need = 16'h0003; cyc(40);
    count_grants(32, 4'd1, cnt);
    check("R5", 8'(cnt), 8'd16);
    // R7 nobody requesting
    tag = "R7"; need = '0; cyc(40);
    // R10 writes during scans in both modes
    tag = "R10"; rand_run(300, 1'b1);
    pair_mode = 1'b0; scan_last = 5'd23; rand_run(300, 1'b1);
    // R8 forced round robin over any table
    tag = "R8"; force_rr = 1'b1; rand_run(100, 1'b1);
    pair_mode = 1'b1; rand_run(60, 1'b0);
    force_rr = 1'b0;
    // R9 long mixed run
    tag = "R9";
    for (int k = 0; k < 20; k++) begin
      pair_mode = 1'($urandom); force_rr = ($urandom % 5 == 0);
      scan_last = 5'($urandom);
      rand_run(150, 1'b1);
    end
    chk_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule